// File: doc/BRIEF.md
# Pixel Display Lookup Table

This block sits in the display path of a frame store. Each stored 8-bit pixel value indexes a 256-entry table of 8-bit display values. The mapped value leaves the block one clock later. A host reprograms the table through a small register port: it selects an entry index with one write, then supplies the new value with a second write.

Table writes are guarded by two control bits that live in two separate control registers. The load-enable bit in the second control register must be set, and the stored-video view bit in the first control register must be clear, both at the moment the value write arrives. A value write that fails either condition is dropped.

A blank bit in the second control register forces the display output to zero. This is commonly set while the table is being rewritten. After reset the table maps every value to itself and all control bits are clear.

Top module: `pix_lut_top`

## Requirements
- R1: After reset, entry i of the table holds the value i for every i from 0 to 255, so a pixel p is output as p.
- R2: After reset, load-enable, stored-view and blank are all clear: the output is not blanked, and a value write is dropped until load-enable is set.
- R3: `pix_out` shows the mapped value of the `pix_in` sampled at the previous rising clock edge, one cycle of latency, in every cycle while blank is clear.
- R4: Host write selects are encoded on `wr_sel` as 0 = control register 0, 1 = control register 1, 2 = entry index, 3 = entry value. With load-enable set and stored-view clear, a value write stores `wr_data` into the entry named by the index register at that clock edge.
- R5: A value write while load-enable (control register 1 bit 0) is clear leaves the table unchanged.
- R6: A value write while stored-view (control register 0 bit 2) is set leaves the table unchanged, even with load-enable set.
- R7: While blank (control register 1 bit 1) is set, `pix_out` is zero for every pixel value, starting with the clock edge after the bit is written.
- R8: Value writes made while blank is set still land in the table, and the mapped values reappear on the output once blank is cleared.
- R9: The index register keeps its value across value writes, so repeated value writes rewrite the same entry and the last one wins.
- R10: A value write changes only the addressed entry; its neighbours keep their contents.
- R11: While `wr_en` is low, `wr_sel` and `wr_data` have no effect on the table or on the control registers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Host write strobe, one write per cycle |
| wr_sel | input | 2 | Host write target: 0 ctl0, 1 ctl1, 2 index, 3 value |
| wr_data | input | 8 | Host write data |
| pix_in | input | 8 | Stored pixel value to map |
| pix_out | output | 8 | Mapped display value, registered |

## Verification
The bench opens both gates one at a time and tries a value write in each half-open state. A design that gates on only one of the two bits would change the output in one of those probes. It rewrites one entry twice and probes the entries on either side of it. A design that moved the index after a value write, or decoded the index wrongly, would show the wrong value or disturb a neighbour. It writes while blanked and then unblanks, which catches a blank that also blocks writes or that leaves a stale value behind. It drives changing pixels on back-to-back cycles and resets in the middle of the run, exposing extra or missing latency and a reset that fails to restore the identity mapping.

// File: rtl/pix_lut_pkg.sv
package pix_lut_pkg;

    typedef enum logic [1:0] {
        SEL_CTL0  = 2'd0,
        SEL_CTL1  = 2'd1,
        SEL_INDEX = 2'd2,
        SEL_VALUE = 2'd3
    } host_sel_e;

    // bit positions inside the two control registers
    localparam int CTL0_VIEW_BIT  = 2;
    localparam int CTL1_LOAD_BIT  = 0;
    localparam int CTL1_BLANK_BIT = 1;

endpackage

// File: rtl/pix_lut_host_regs.sv
module pix_lut_host_regs
    import pix_lut_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [1:0]   wr_sel,
    input  logic [W-1:0] wr_data,
    output logic         load_en,
    output logic         view_stored,
    output logic         blank,
    output logic [W-1:0] index,
    output logic         tbl_we,
    output logic [W-1:0] tbl_wdata
);

    typedef struct packed {
        logic         view;
        logic         load;
        logic         blank;
        logic [W-1:0] index;
    } regs_t;

    regs_t regs_d, regs_q;
    host_sel_e sel;

    assign sel = host_sel_e'(wr_sel);

    always_comb begin
        regs_d = regs_q;
        if (wr_en) begin
            unique case (sel)
                SEL_CTL0:  regs_d.view = wr_data[CTL0_VIEW_BIT];
                SEL_CTL1: begin
                    regs_d.load  = wr_data[CTL1_LOAD_BIT];
                    regs_d.blank = wr_data[CTL1_BLANK_BIT];
                end
                SEL_INDEX: regs_d.index = wr_data;
                SEL_VALUE: ;
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    // both gates are judged on the registered control state
    assign tbl_we      = wr_en && (sel == SEL_VALUE) && regs_q.load && !regs_q.view;
    assign tbl_wdata   = wr_data;
    assign load_en     = regs_q.load;
    assign view_stored = regs_q.view;
    assign blank       = regs_q.blank;
    assign index       = regs_q.index;

endmodule

// File: rtl/pix_lut_store.sv
module pix_lut_store #(
    parameter int W     = 8,
    localparam int DEPTH = 1 << W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [W-1:0]     waddr,
    input  logic [W-1:0]     wdata,
    input  logic [W-1:0]     raddr,
    output logic [W-1:0]     rdata,
    output logic [DEPTH*W-1:0] flat
);

    logic [W-1:0] ent_d [DEPTH];
    logic [W-1:0] ent_q [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        always_comb begin
            ent_d[i] = ent_q[i];
            if (we && (waddr == W'(i))) begin
                ent_d[i] = wdata;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ent_q[i] <= W'(i);
            end else begin
                ent_q[i] <= ent_d[i];
            end
        end

        assign flat[i*W +: W] = ent_q[i];
    end

    assign rdata = ent_q[raddr];

endmodule

// File: rtl/pix_lut_out_stage.sv
module pix_lut_out_stage #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         blank,
    input  logic [W-1:0] mapped,
    output logic [W-1:0] pix_out
);

    logic [W-1:0] pix_d, pix_q;

    always_comb begin
        pix_d = blank ? '0 : mapped;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pix_q <= '0;
        end else begin
            pix_q <= pix_d;
        end
    end

    assign pix_out = pix_q;

endmodule

// File: rtl/pix_lut_top.sv
module pix_lut_top #(
    parameter int W = 8,
    localparam int DEPTH = 1 << W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [1:0]   wr_sel,
    input  logic [W-1:0] wr_data,
    input  logic [W-1:0] pix_in,
    output logic [W-1:0] pix_out
);

    logic         load_en;
    logic         view_stored;
    logic         blank;
    logic [W-1:0] index;
    logic         tbl_we;
    logic [W-1:0] tbl_wdata;
    logic [W-1:0] rd_val;
    logic [DEPTH*W-1:0] tbl_flat;

    pix_lut_host_regs #(.W(W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_sel      (wr_sel),
        .wr_data     (wr_data),
        .load_en     (load_en),
        .view_stored (view_stored),
        .blank       (blank),
        .index       (index),
        .tbl_we      (tbl_we),
        .tbl_wdata   (tbl_wdata)
    );

    pix_lut_store #(.W(W)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (tbl_we),
        .waddr (index),
        .wdata (tbl_wdata),
        .raddr (pix_in),
        .rdata (rd_val),
        .flat  (tbl_flat)
    );

    pix_lut_out_stage #(.W(W)) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .blank   (blank),
        .mapped  (rd_val),
        .pix_out (pix_out)
    );

endmodule

// File: rtl/pix_lut_checker.sv
module pix_lut_checker #(
    parameter int W = 8,
    localparam int DEPTH = 1 << W
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [1:0]       wr_sel,
    input logic [W-1:0]     wr_data,
    input logic [W-1:0]     pix_out,
    input logic             load_en,
    input logic             view_stored,
    input logic             blank,
    input logic [W-1:0]     index,
    input logic [W-1:0]     rd_val,
    input logic [DEPTH*W-1:0] tbl_flat
);

    logic         val_wr;
    logic [W-1:0] ent_at_index;

    assign val_wr       = wr_en && (wr_sel == 2'd3);
    assign ent_at_index = tbl_flat[index*W +: W];

    // R4 and R9: a permitted value write lands at the held index
    assert_value_lands_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (val_wr && load_en && !view_stored) |=> (ent_at_index == $past(wr_data)));

    // R5: load gate closed
    assert_load_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (val_wr && !load_en) |=> $stable(tbl_flat));

    // R6: stored-view gate closed
    assert_view_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (val_wr && view_stored) |=> $stable(tbl_flat));

    // R11: no strobe, no change
    assert_idle_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(tbl_flat) && $stable(index) && $stable(blank)
                    && $stable(load_en) && $stable(view_stored)));

    // R3: one cycle from lookup to output
    assert_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !blank |=> (pix_out == $past(rd_val)));

    // R7: blanked output is dark
    assert_blank_dark_R7: assert property (@(posedge clk) disable iff (!rst_n)
        blank |=> (pix_out == '0));

endmodule

bind pix_lut_top pix_lut_checker #(.W(W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_sel      (wr_sel),
    .wr_data     (wr_data),
    .pix_out     (pix_out),
    .load_en     (load_en),
    .view_stored (view_stored),
    .blank       (blank),
    .index       (index),
    .rd_val      (rd_val),
    .tbl_flat    (tbl_flat)
);

// File: tb/pix_lut_top_test.sv
module pix_lut_top_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = 2'd0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] pix_in = 8'h00;
    logic [7:0] pix_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    pix_lut_top uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .pix_in  (pix_in),
        .pix_out (pix_out)
    );

    // vector: {en, sel, wdata, probe pixel, expected output}
    localparam int NV = 19;
    localparam logic [26:0] VEC [NV] = '{
        {1'b0, 2'd0, 8'h00, 8'h37, 8'h37},  // R1 identity
        {1'b1, 2'd2, 8'h37, 8'h37, 8'h37},  // index write alone
        {1'b1, 2'd3, 8'hA5, 8'h37, 8'h37},  // R2 R5 load gate shut
        {1'b1, 2'd1, 8'h01, 8'h37, 8'h37},  // load on
        {1'b1, 2'd0, 8'h04, 8'h37, 8'h37},  // view stored on
        {1'b1, 2'd3, 8'hA5, 8'h37, 8'h37},  // R6 view gate shut
        {1'b1, 2'd0, 8'h00, 8'h37, 8'h37},  // view off
        {1'b1, 2'd3, 8'hA5, 8'h37, 8'hA5},  // R4 write lands
        {1'b0, 2'd0, 8'h00, 8'h38, 8'h38},  // R10 upper neighbour
        {1'b0, 2'd0, 8'h00, 8'h36, 8'h36},  // R10 lower neighbour
        {1'b1, 2'd3, 8'h5A, 8'h37, 8'h5A},  // R9 same entry rewritten
        {1'b1, 2'd1, 8'h03, 8'h37, 8'h00},  // R7 blank
        {1'b0, 2'd0, 8'h00, 8'hFF, 8'h00},  // R7 blank any pixel
        {1'b1, 2'd3, 8'h11, 8'h37, 8'h00},  // R8 write while blank
        {1'b1, 2'd1, 8'h01, 8'h37, 8'h11},  // R8 unblank shows it
        {1'b1, 2'd1, 8'h00, 8'h37, 8'h11},  // load off
        {1'b0, 2'd3, 8'h22, 8'h37, 8'h11},  // R11 strobe low value
        {1'b0, 2'd1, 8'h02, 8'h37, 8'h11},  // R11 strobe low blank
        {1'b0, 2'd0, 8'h00, 8'hFF, 8'hFF}   // R1 top entry
    };
    localparam int VREQ [NV] = '{1,4,5,4,6,6,4,4,10,10,9,7,7,8,8,4,11,11,1};

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: pix_out=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic host_cycle(input logic en, input logic [1:0] sel, input logic [7:0] d);
        @(negedge clk);
        wr_en = en; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic probe(input logic [7:0] p, output logic [7:0] o);
        pix_in = p;
        @(negedge clk);
        o = pix_out;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: run hung, expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] o;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R2: reset state, not blanked, identity
        probe(8'h00, o); check("R2", o, 8'h00);
        probe(8'h80, o); check("R1", o, 8'h80);

        for (int k = 0; k < NV; k++) begin
            logic [26:0] v;
            string tag;
            v = VEC[k];
            host_cycle(v[26], v[25:24], v[23:16]);
            probe(v[15:8], o);
            tag = $sformatf("R%0d vec%0d", VREQ[k], k);
            check(tag, o, v[7:0]);
        end

        // R3: back-to-back changing pixels, one cycle each
        @(negedge clk);
        pix_in = 8'h10;
        @(negedge clk);
        check("R3", pix_out, 8'h10);
        pix_in = 8'h37;
        @(negedge clk);
        check("R3", pix_out, 8'h11);
        pix_in = 8'h20;
        @(negedge clk);
        check("R3", pix_out, 8'h20);

        // R4 boundaries: entries 0x00 and 0xFF
        host_cycle(1'b1, 2'd1, 8'h01);
        host_cycle(1'b1, 2'd2, 8'hFF);
        host_cycle(1'b1, 2'd3, 8'h3C);
        host_cycle(1'b1, 2'd2, 8'h00);
        host_cycle(1'b1, 2'd3, 8'hC3);
        probe(8'hFF, o); check("R4 top", o, 8'h3C);
        probe(8'h00, o); check("R4 bottom", o, 8'hC3);
        probe(8'h01, o); check("R10", o, 8'h01);

        // R1 R2: reset mid-run restores identity and closes the gate
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        probe(8'hFF, o); check("R1 after reset", o, 8'hFF);
        probe(8'h37, o); check("R1 after reset", o, 8'h37);
        host_cycle(1'b1, 2'd3, 8'h99);
        probe(8'h00, o); check("R2 gate shut after reset", o, 8'h00);

        finish_run();
    end

endmodule